// File: doc/BRIEF.md
# Multi-Source CPU Reset Sequencer

This block merges three reset causes into one reset line for a processor core. The first cause is a supply-good level from an analog monitor. The second is a timeout from a built-in watchdog. The third is an external reset pin.

- While the supply is bad, the reset line is held with no time limit. Once the supply recovers, the line stays held for a fixed oscillator start-up count before release.
- A drop in supply while the core runs is a brownout. It is handled exactly like a fresh power-up.
- A watchdog timeout or an external reset only produces a short, fixed-length reset. These resets leave a software-visible power-cause flag untouched.

Every cause leads the core to the same restart address, so the block drives a single reset output and carries no per-cause vector. The supply-good input also serves as the block's own synchronous active-low reset. The monitor is expected to deliver it already aligned to the clock.

The watchdog counts clock cycles while it is enabled. The interval is picked by a 2-bit select. Software restarts the interval with a kick strobe. The power-cause flag is cleared through a one-cycle write strobe with an 8-bit data word.

Top module: `cpu_reset_seq`

## Requirements
- R1: While `pwr_ok` is low, `cpu_rst` is 1 from the first clock edge that samples it low, and it stays 1 for as long as `pwr_ok` stays low.
- R2: After `pwr_ok` rises, `cpu_rst` stays 1 for exactly STARTUP_CYC (default 65536) rising edges and is 0 after the STARTUP_CYC-th edge, provided no other cause is active.
- R3: A drop of `pwr_ok` at any time restarts the start-up hold, including a drop in the middle of the count. After `pwr_ok` rises again, the full STARTUP_CYC count is required.
- R4: `pwr_flag` is 1 after any power sequence. It goes to 0 only on a clock edge where `cfg_wr` is 1 and bit 6 of `cfg_wdata` is 0.
- R5: A write with bit 6 of `cfg_wdata` set to 1 leaves `pwr_flag` unchanged, as does any cycle without `cfg_wr`. Such writes also have no effect on `cpu_rst`.
- R6: Watchdog resets and external resets leave `pwr_flag` unchanged.
- R7: With `wdt_en` high, the watchdog fires on the 2^N-th edge after its last clear. N is 6, 8, 10 or 12 for `wdt_sel` 0, 1, 2 or 3. The reset that follows lasts exactly 2 machine cycles of 4 clocks each, which is 8 clocks.
- R8: A `wdt_kick` pulse clears the watchdog count on that edge, even on the edge that would have fired. A new full interval starts after it.
- R9: While `wdt_en` is low, or while `cpu_rst` is 1, the watchdog count is held at zero and the watchdog does not fire.
- R10: `ext_rst_pin` passes through a two-flop synchroniser, so `cpu_rst` rises on the second edge after the pin goes high. `cpu_rst` stays 1 while the synchronised level is high and for 8 clocks after it falls, and goes low on the 10th edge after the pin falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_ok | input | 1 | Supply good, clock-aligned; low is the block's synchronous reset and a power reset cause |
| ext_rst_pin | input | 1 | External reset request, active high, asynchronous |
| wdt_en | input | 1 | Watchdog enable |
| wdt_sel | input | 2 | Watchdog interval select |
| wdt_kick | input | 1 | Watchdog restart strobe |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data; bit 6 writes the power-cause flag |
| cpu_rst | output | 1 | Reset to the core, active high |
| pwr_flag | output | 1 | Power-cause flag |

## Verification
The checker enforces the following on every cycle:
- the reset line and the flag are set on the edge where the supply comes back;
- the reset line stays high through the start-up window, with the window tracked by a counter in the checker;
- the flag changes only on a clearing write;
- a watchdog firing is a single pulse, and it never occurs while the watchdog is disabled;
- a high synchronised external level always leads to reset.

The exact watchdog interval for each select value, the effect of kicks at various points in the interval, and the 8-clock hold width can only be shown by the bench's scenarios. The same holds for the two-edge synchroniser latency, the 10-edge release after the pin falls, and a brownout that restarts a half-finished start-up count.

// File: rtl/rstseq_pkg.sv
// Shared constants and helpers for the reset sequencer.
// Assumes the watchdog interval table packs one exponent per select value.
package rstseq_pkg;
    localparam int SEL_W = 2;
    localparam int N_SEL = 1 << SEL_W;
    localparam int EXP_W = 5;
    localparam int TBL_W = N_SEL * EXP_W;

    // Exponent stored for one select value
    function automatic int exp_of(input logic [TBL_W-1:0] tbl, input int idx);
        return int'(tbl[idx*EXP_W +: EXP_W]);
    endfunction

    // Largest exponent in the table, which sets the watchdog counter width
    function automatic int exp_max(input logic [TBL_W-1:0] tbl);
        int m;
        m = 1;
        for (int i = 0; i < N_SEL; i++) begin
            if (exp_of(tbl, i) > m) m = exp_of(tbl, i);
        end
        return m;
    endfunction
endpackage

// File: rtl/rstseq_sync2.sv
// Two-flop synchroniser for the external reset request.
// Assumes the input may change at any time relative to clk.
module rstseq_sync2 (
    input  logic clk,
    input  logic pwr_ok,
    input  logic d,
    output logic q
);
    logic meta_q;
    logic sync_q;

    // Shift the raw level through two flops
    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/rstseq_stretch.sv
// Pulse stretcher: active while trig is high and for LOAD clocks after it drops.
// Assumes LOAD >= 1.
module rstseq_stretch #(
    parameter int LOAD = 8
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(LOAD + 1);

    logic [CW-1:0] cnt_q;

    // Reload while triggered, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!pwr_ok)
            cnt_q <= '0;
        else if (trig)
            cnt_q <= CW'(LOAD);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active = trig | (cnt_q != '0);
endmodule

// File: rtl/rstseq_por.sv
// Power-on start-up hold and the power-cause flag.
// Assumes pwr_ok is already aligned to clk; it acts as the synchronous reset here.
module rstseq_por #(
    parameter int STARTUP_CYC = 65536,
    parameter int FLAG_BIT    = 6
) (
    input  logic       clk,
    input  logic       pwr_ok,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic       start_hold,
    output logic       flag
);
    localparam int CW = $clog2(STARTUP_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          flag_q;

    // Count start-up clocks after supply recovers, then mark done
    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(STARTUP_CYC - 1)) done_q <= 1'b1;
        end
    end

    // Force the flag while supply is bad; software clears it by writing 0
    always_ff @(posedge clk) begin
        if (!pwr_ok)
            flag_q <= 1'b1;
        else if (cfg_wr && !cfg_wdata[FLAG_BIT])
            flag_q <= 1'b0;
    end

    assign start_hold = !done_q;
    assign flag       = flag_q;
endmodule

// File: rtl/rstseq_wdt.sv
// Watchdog interval counter with selectable 2^N timeout and restart strobe.
// Assumes clr is high whenever any reset is driven to the core.
module rstseq_wdt
    import rstseq_pkg::*;
#(
    parameter logic [TBL_W-1:0] EXP_TBL = {5'd12, 5'd10, 5'd8, 5'd6}
) (
    input  logic             clk,
    input  logic             pwr_ok,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             kick,
    input  logic             clr,
    output logic             fire
);
    localparam int CW = exp_max(EXP_TBL);

    logic [CW-1:0] lim_tbl [N_SEL];
    logic [CW-1:0] cnt_q;
    logic          fire_q;

    for (genvar g = 0; g < N_SEL; g++) begin : g_lim
        localparam int E = exp_of(EXP_TBL, g);
        assign lim_tbl[g] = CW'((longint'(1) << E) - 1);
    end

    // Count while enabled; clear on kick, disable or reset; flag a one-clock timeout
    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (!en || clr || kick) begin
                cnt_q <= '0;
            end else if (cnt_q == lim_tbl[sel]) begin
                cnt_q  <= '0;
                fire_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign fire = fire_q;
endmodule

// File: rtl/cpu_reset_seq.sv
// Reset sequencer top: merges supply, watchdog and external causes into cpu_rst.
// Assumes pwr_ok is clock-aligned; one machine cycle is MC_CLKS clocks.
module cpu_reset_seq
    import rstseq_pkg::*;
#(
    parameter int               STARTUP_CYC = 65536,
    parameter int               MC_CLKS     = 4,
    parameter int               HOLD_MC     = 2,
    parameter int               FLAG_BIT    = 6,
    parameter logic [TBL_W-1:0] WDT_EXP_TBL = {5'd12, 5'd10, 5'd8, 5'd6}
) (
    input  logic       clk,
    input  logic       pwr_ok,
    input  logic       ext_rst_pin,
    input  logic       wdt_en,
    input  logic [1:0] wdt_sel,
    input  logic       wdt_kick,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic       cpu_rst,
    output logic       pwr_flag
);
    localparam int HOLD_CLKS = MC_CLKS * HOLD_MC;

    logic por_hold;
    logic ext_sync;
    logic ext_active;
    logic wdt_fire;
    logic wdt_active;

    rstseq_por #(.STARTUP_CYC(STARTUP_CYC), .FLAG_BIT(FLAG_BIT)) u_por (
        .clk(clk), .pwr_ok(pwr_ok), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .start_hold(por_hold), .flag(pwr_flag)
    );

    rstseq_sync2 u_ext_sync (
        .clk(clk), .pwr_ok(pwr_ok), .d(ext_rst_pin), .q(ext_sync)
    );

    rstseq_stretch #(.LOAD(HOLD_CLKS)) u_ext_hold (
        .clk(clk), .pwr_ok(pwr_ok), .trig(ext_sync), .active(ext_active)
    );

    rstseq_wdt #(.EXP_TBL(WDT_EXP_TBL)) u_wdt (
        .clk(clk), .pwr_ok(pwr_ok), .en(wdt_en), .sel(wdt_sel),
        .kick(wdt_kick), .clr(cpu_rst), .fire(wdt_fire)
    );

    // The fire pulse itself is the first hold clock, so reload one less
    rstseq_stretch #(.LOAD(HOLD_CLKS - 1)) u_wdt_hold (
        .clk(clk), .pwr_ok(pwr_ok), .trig(wdt_fire), .active(wdt_active)
    );

    assign cpu_rst = por_hold | ext_active | wdt_active;
endmodule

// File: rtl/rstseq_chk.sv
// Property checker for cpu_reset_seq, attached with bind below.
// Tracks the start-up window with its own counter.
module rstseq_chk #(
    parameter int STARTUP_CYC = 65536,
    parameter int FLAG_BIT    = 6
) (
    input logic       clk,
    input logic       pwr_ok,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic       wdt_en,
    input logic       cpu_rst,
    input logic       pwr_flag,
    input logic       wdt_fire,
    input logic       ext_sync
);
    localparam int CW = $clog2(STARTUP_CYC + 1);

    logic [CW-1:0] up_cnt_q;

    // Clocks since supply recovered, saturating at the start-up length
    always_ff @(posedge clk) begin
        if (!pwr_ok)
            up_cnt_q <= '0;
        else if (up_cnt_q != CW'(STARTUP_CYC))
            up_cnt_q <= up_cnt_q + 1'b1;
    end

    // R1
    pwr_return_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(pwr_ok) |-> (cpu_rst && pwr_flag));

    // R2
    startup_hold_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
        (up_cnt_q < CW'(STARTUP_CYC)) |-> cpu_rst);

    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
        (cfg_wr && !cfg_wdata[FLAG_BIT]) |=> !pwr_flag);

    // R5
    flag_keep_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
        (!cfg_wr || cfg_wdata[FLAG_BIT]) |=> (pwr_flag == $past(pwr_flag)));

    // R7
    wdt_single_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
        wdt_fire |=> !wdt_fire);

    // R9
    wdt_off_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
        !wdt_en |=> !wdt_fire);

    // R10
    ext_level_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
        ext_sync |=> cpu_rst);
endmodule

bind cpu_reset_seq rstseq_chk #(.STARTUP_CYC(STARTUP_CYC), .FLAG_BIT(FLAG_BIT)) u_chk (
    .clk(clk), .pwr_ok(pwr_ok), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .wdt_en(wdt_en), .cpu_rst(cpu_rst), .pwr_flag(pwr_flag),
    .wdt_fire(wdt_fire), .ext_sync(ext_sync)
);

// File: tb/cpu_reset_seq_tb.sv
`timescale 1ns/1ps
module cpu_reset_seq_tb;
    logic       clk = 1'b0;
    logic       pwr_ok = 1'b0;
    logic       ext_rst_pin = 1'b0;
    logic       wdt_en = 1'b0;
    logic [1:0] wdt_sel = 2'd0;
    logic       wdt_kick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       cpu_rst;
    logic       pwr_flag;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    cpu_reset_seq u_dut (
        .clk(clk), .pwr_ok(pwr_ok), .ext_rst_pin(ext_rst_pin), .wdt_en(wdt_en),
        .wdt_sel(wdt_sel), .wdt_kick(wdt_kick), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cpu_rst(cpu_rst), .pwr_flag(pwr_flag)
    );

    // Watchdog vectors: select, kick edge (0 = none), expected firing edge
    localparam int NV = 7;
    localparam int VEC [NV][3] = '{
        '{0, 0, 64}, '{1, 0, 256}, '{2, 0, 1024}, '{3, 0, 4096},
        '{0, 30, 94}, '{0, 64, 128}, '{1, 255, 511}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Edges until cpu_rst reads the given level, bounded
    task automatic edges_until(input logic lvl, input int lim, output int n);
        n = 0;
        while (cpu_rst !== lvl && n < lim) begin
            tick();
            n++;
        end
    endtask

    // Width of a reset pulse that is currently high
    task automatic pulse_width(output int w);
        w = 1;
        while (w < 100) begin
            tick();
            if (cpu_rst) w++;
            else break;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL run timeout");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        int w;
        int bad;
        @(negedge clk);
        repeat (5) tick();
        chk(cpu_rst === 1'b1, "R1 reset while supply low", cpu_rst, 1);
        chk(pwr_flag === 1'b1, "R4 flag while supply low", pwr_flag, 1);

        // Power-up start-up hold
        pwr_ok = 1'b1;
        edges_until(1'b0, 70000, n);
        chk(n == 65536, "R2 start-up hold length", n, 65536);
        chk(pwr_flag === 1'b1, "R4 flag after power-up", pwr_flag, 1);
        repeat (3) tick();
        chk(cpu_rst === 1'b0, "R2 released and idle", cpu_rst, 0);

        // Flag writes
        cfg_wr = 1'b1; cfg_wdata = 8'hFF; tick(); cfg_wr = 1'b0;
        chk(pwr_flag === 1'b1, "R5 write bit6=1 keeps flag", pwr_flag, 1);
        cfg_wr = 1'b1; cfg_wdata = 8'hBF; tick(); cfg_wr = 1'b0;
        chk(pwr_flag === 1'b0, "R4 write bit6=0 clears flag", pwr_flag, 0);
        cfg_wr = 1'b1; cfg_wdata = 8'h40; tick(); cfg_wr = 1'b0;
        chk(pwr_flag === 1'b0, "R5 write bit6=1 cannot set flag", pwr_flag, 0);
        chk(cpu_rst === 1'b0, "R5 write does not reset", cpu_rst, 0);

        // Disabled watchdog never fires
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            tick();
            if (cpu_rst) bad++;
        end
        chk(bad == 0, "R9 disabled watchdog silent", bad, 0);

        // Disable clears the count
        wdt_sel = 2'd0; wdt_en = 1'b1;
        repeat (40) tick();
        wdt_en = 1'b0; tick(); wdt_en = 1'b1;
        edges_until(1'b1, 1000, n);
        chk(n == 64, "R9 disable clears count", n, 64);
        wdt_en = 1'b0;
        edges_until(1'b0, 100, n);
        tick();

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            bit fired;
            wdt_sel = VEC[v][0][1:0];
            wdt_en = 1'b1;
            n = 0;
            fired = 1'b0;
            while (!fired && n < 10000) begin
                wdt_kick = (n + 1 == VEC[v][1]);
                @(posedge clk);
                n++;
                @(negedge clk);
                wdt_kick = 1'b0;
                if (cpu_rst) fired = 1'b1;
            end
            if (VEC[v][1] == 0)
                chk(n == VEC[v][2], "R7 timeout edge", n, VEC[v][2]);
            else
                chk(n == VEC[v][2], "R8 kick restarts interval", n, VEC[v][2]);
            pulse_width(w);
            wdt_en = 1'b0;
            chk(w == 8, "R7 hold width", w, 8);
            chk(pwr_flag === 1'b0, "R6 watchdog keeps flag", pwr_flag, 0);
            tick();
        end

        // External reset
        ext_rst_pin = 1'b1;
        tick();
        chk(cpu_rst === 1'b0, "R10 first sync edge", cpu_rst, 0);
        tick();
        chk(cpu_rst === 1'b1, "R10 second sync edge", cpu_rst, 1);
        repeat (20) tick();
        chk(cpu_rst === 1'b1, "R10 held while pin high", cpu_rst, 1);
        ext_rst_pin = 1'b0;
        edges_until(1'b0, 100, n);
        chk(n == 10, "R10 release after pin falls", n, 10);
        chk(pwr_flag === 1'b0, "R6 external keeps flag", pwr_flag, 0);

        // Brownout, with a second drop in mid count
        wdt_sel = 2'd0; wdt_en = 1'b1;
        pwr_ok = 1'b0;
        repeat (3) tick();
        chk(cpu_rst === 1'b1, "R3 brownout asserts reset", cpu_rst, 1);
        chk(pwr_flag === 1'b1, "R3 brownout sets flag", pwr_flag, 1);
        pwr_ok = 1'b1;
        repeat (30000) tick();
        chk(cpu_rst === 1'b1, "R3 still in start-up", cpu_rst, 1);
        pwr_ok = 1'b0; tick(); pwr_ok = 1'b1;
        edges_until(1'b0, 70000, n);
        chk(n == 65536, "R3 full count after second drop", n, 65536);
        edges_until(1'b1, 1000, n);
        chk(n == 64, "R9 watchdog held during reset", n, 64);
        pulse_width(w);
        wdt_en = 1'b0;
        chk(pwr_flag === 1'b1, "R6 watchdog leaves set flag", pwr_flag, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule